// File: doc/BRIEF.md
# T1 to 2.048 Mb/s Backplane Mapper

This block sits after a T1 receive buffer, in the system clock domain, and lays T1 frames onto a serial backplane. Each T1 frame is an F-bit followed by 24 eight-bit channels. The system clock runs at one backplane bit per cycle. The block pulls one T1 bit at a time from the upstream buffer through a read strobe. The buffer presents the next bit on `in_bit` in the same cycle, first-word-fall-through style, and consumes it at the clock edge.

In 1.544 MHz mode the 193-bit frame passes straight through. In 2.048 MHz mode the frame is 32 eight-bit timeslots long. Every fourth timeslot is a filler slot that carries all ones and is flagged on a blanking output. The F-bit is taken from the buffer and thrown away. The 24 channels fill the remaining timeslots.

The frame alignment comes from one of two sources. The block can drive a one-cycle sync pulse on each frame or multiframe boundary. It can instead follow an external sync input.

Top module: `t1_backplane_mapper`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, the block is at bit 0 of frame 0 of a multiframe. In 1.544 MHz mode, with sync driven by the block, this means that `sync_out` and `rd_en` are high and `blank_out` is low.
- R2: With `mode_bp`=0 the frame is 193 cycles long. `rd_en` is high in every cycle, `ser_out` equals `in_bit`, and `blank_out` stays low.
- R3: With `mode_bp`=1 the frame is 256 cycles long. Cycle p of the frame belongs to timeslot p/8. In timeslots 0, 4, 8, 12, 16, 20, 24 and 28, `ser_out` and `blank_out` are both high.
- R4: With `mode_bp`=1, the only cycle of a filler timeslot in which `rd_en` is high is bit 0 of the frame. That read consumes the F-bit, which never appears on `ser_out`. Exactly 193 bits are read per frame.
- R5: With `mode_bp`=1, every timeslot t that is not a filler carries T1 channel t - t/4 - 1, counting channels from 0. The channel is sent most significant bit first, `rd_en` is high, and `ser_out` equals `in_bit`.
- R6: With `sync_ext`=0 and `sync_mf`=0, `sync_out` is high for exactly one cycle, at bit 0 of every frame.
- R7: With `sync_ext`=0 and `sync_mf`=1, `sync_out` is high only at bit 0 of the first frame of each multiframe of `MF_FRAMES` frames (12 by default, 24 allowed).
- R8: With `sync_ext`=1, `sync_out` stays low. If `sync_in` is high in a cycle, the next cycle is bit 0 of the first frame of a multiframe.
- R9: With `sync_ext`=0, `sync_in` has no effect on the frame position or on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one backplane bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_bp | input | 1 | 0: 1.544 MHz pass-through, 1: 2.048 MHz mapping |
| sync_ext | input | 1 | 1: frame alignment taken from `sync_in`, 0: block drives `sync_out` |
| sync_mf | input | 1 | When driving sync: 1 pulses per multiframe, 0 per frame |
| sync_in | input | 1 | External frame sync; the cycle after a high is frame bit 0 |
| in_bit | input | 1 | Next T1 bit from the upstream buffer |
| rd_en | output | 1 | Consumes `in_bit` at the clock edge |
| ser_out | output | 1 | Serial backplane data |
| blank_out | output | 1 | High during filler timeslots |
| sync_out | output | 1 | Frame or multiframe sync pulse |

## Verification
The following rules are checked by assertions on every cycle:
- blanking stays low in pass-through mode;
- a blanked bit is always a one;
- every mapped bit is read from the buffer and forwarded unchanged;
- `sync_out` stays silent under external sync and never lasts more than one cycle;
- a read inside a filler slot only happens at frame bit 0.

Some properties can only be shown by the bench scenarios, which compare the outputs with a model computed from frame position and timeslot arithmetic. These are:
- the placement of each channel in its timeslot, MSB first;
- the 193 reads per frame;
- the spacing of multiframe pulses;
- realignment from an external sync pulse in mid-frame;
- the fact that `sync_in` is ignored while the block drives sync.

// File: rtl/t1map_pkg.sv
package t1map_pkg;
    localparam int CH_BITS       = 8;
    localparam int T1_CHANNELS   = 24;
    localparam int BP_SLOTS      = 32;
    localparam int FILL_STRIDE   = 4;
    localparam int T1_FRAME_BITS = T1_CHANNELS * CH_BITS + 1;
    localparam int BP_FRAME_BITS = BP_SLOTS * CH_BITS;
    localparam int POS_W         = $clog2(BP_FRAME_BITS);
    localparam int SLOT_W        = $clog2(BP_SLOTS);
endpackage

// File: rtl/t1map_timing.sv
module t1map_timing
    import t1map_pkg::*;
#(
    parameter int MF_FRAMES = 12,
    localparam int FRM_W = $clog2(MF_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_bp,
    input  logic             resync,
    output logic [POS_W-1:0] pos,
    output logic [FRM_W-1:0] frm
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [FRM_W-1:0] frm;
    } tstate_t;

    localparam logic [POS_W-1:0] T1_LAST = POS_W'(T1_FRAME_BITS - 1);
    localparam logic [POS_W-1:0] BP_LAST = POS_W'(BP_FRAME_BITS - 1);
    localparam logic [FRM_W-1:0] MF_LAST = FRM_W'(MF_FRAMES - 1);

    tstate_t st_d, st_q;
    logic [POS_W-1:0] last_pos;

    always_comb begin
        st_d     = st_q;
        last_pos = mode_bp ? BP_LAST : T1_LAST;
        if (resync) begin
            st_d.pos = '0;
            st_d.frm = '0;
        end else if (st_q.pos >= last_pos) begin
            st_d.pos = '0;
            st_d.frm = (st_q.frm == MF_LAST) ? '0 : st_q.frm + 1'b1;
        end else begin
            st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos = st_q.pos;
    assign frm = st_q.frm;
endmodule

// File: rtl/t1map_slot_decode.sv
module t1map_slot_decode
    import t1map_pkg::*;
(
    input  logic             mode_bp,
    input  logic [POS_W-1:0] pos,
    output logic             filler,
    output logic             take_bit
);
    logic [SLOT_W-1:0] slot;
    logic              slot_is_fill;

    assign slot = SLOT_W'(pos / POS_W'(CH_BITS));

    generate
        if ((FILL_STRIDE & (FILL_STRIDE - 1)) == 0) begin : g_pow2
            assign slot_is_fill = (slot & SLOT_W'(FILL_STRIDE - 1)) == '0;
        end else begin : g_mod
            assign slot_is_fill = (slot % SLOT_W'(FILL_STRIDE)) == '0;
        end
    endgenerate

    always_comb begin
        filler   = mode_bp && slot_is_fill;
        take_bit = !filler || (pos == '0);
    end
endmodule

// File: rtl/t1map_sync_gen.sv
module t1map_sync_gen
    import t1map_pkg::*;
#(
    parameter int MF_FRAMES = 12,
    localparam int FRM_W = $clog2(MF_FRAMES)
) (
    input  logic             sync_ext,
    input  logic             sync_mf,
    input  logic [POS_W-1:0] pos,
    input  logic [FRM_W-1:0] frm,
    output logic             sync_out
);
    always_comb begin
        sync_out = !sync_ext && (pos == '0) && (!sync_mf || (frm == '0));
    end
endmodule

// File: rtl/t1_backplane_mapper.sv
module t1_backplane_mapper
    import t1map_pkg::*;
#(
    parameter int MF_FRAMES = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_bp,
    input  logic sync_ext,
    input  logic sync_mf,
    input  logic sync_in,
    input  logic in_bit,
    output logic rd_en,
    output logic ser_out,
    output logic blank_out,
    output logic sync_out
);
    localparam int FRM_W = $clog2(MF_FRAMES);

    logic [POS_W-1:0] pos_w;
    logic [FRM_W-1:0] frm_w;
    logic             filler_w;
    logic             take_w;
    logic             resync_w;

    assign resync_w = sync_ext && sync_in;

    t1map_timing #(.MF_FRAMES(MF_FRAMES)) i_timing (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_bp (mode_bp),
        .resync  (resync_w),
        .pos     (pos_w),
        .frm     (frm_w)
    );

    t1map_slot_decode i_decode (
        .mode_bp  (mode_bp),
        .pos      (pos_w),
        .filler   (filler_w),
        .take_bit (take_w)
    );

    t1map_sync_gen #(.MF_FRAMES(MF_FRAMES)) i_sync (
        .sync_ext (sync_ext),
        .sync_mf  (sync_mf),
        .pos      (pos_w),
        .frm      (frm_w),
        .sync_out (sync_out)
    );

    assign rd_en     = take_w;
    assign blank_out = filler_w;
    assign ser_out   = filler_w ? 1'b1 : in_bit;
endmodule

// File: rtl/t1map_checker.sv
module t1map_checker
    import t1map_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             mode_bp,
    input logic             sync_ext,
    input logic             in_bit,
    input logic             rd_en,
    input logic             ser_out,
    input logic             blank_out,
    input logic             sync_out,
    input logic [POS_W-1:0] pos
);
    a_r2_no_blank_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_bp |-> (!blank_out && rd_en));

    a_r3_filler_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        blank_out |-> ser_out);

    a_r4_filler_read_only_fbit: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_out && rd_en) |-> (pos == '0));

    a_r5_mapped_bit_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bp && !blank_out) |-> (rd_en && (ser_out == in_bit)));

    a_r6_sync_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_out && !sync_ext) |=> !sync_out);

    a_r8_sync_quiet_when_ext: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ext |-> !sync_out);
endmodule

bind t1_backplane_mapper t1map_checker i_t1map_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_bp   (mode_bp),
    .sync_ext  (sync_ext),
    .in_bit    (in_bit),
    .rd_en     (rd_en),
    .ser_out   (ser_out),
    .blank_out (blank_out),
    .sync_out  (sync_out),
    .pos       (pos_w)
);

// File: tb/test_t1_backplane_mapper.sv
module test_t1_backplane_mapper;
    localparam int MF = 12;
    localparam int T1B = 193;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_bp = 1'b0, sync_ext = 1'b0, sync_mf = 1'b0, sync_in = 1'b0, in_bit = 1'b0;
    logic rd_en, ser_out, blank_out, sync_out;

    int checks = 0, fails = 0;
    int bpos = 0, bfrm = 0, popcnt = 0, fb = 0, pops_in_frame = 0;

    always #10 clk = ~clk;

    t1_backplane_mapper #(.MF_FRAMES(MF)) i_t1_backplane_mapper (
        .clk(clk), .rst_n(rst_n), .mode_bp(mode_bp), .sync_ext(sync_ext),
        .sync_mf(sync_mf), .sync_in(sync_in), .in_bit(in_bit), .rd_en(rd_en),
        .ser_out(ser_out), .blank_out(blank_out), .sync_out(sync_out)
    );

    function automatic logic [7:0] pat(int f, int ch);
        return 8'((f * 37 + ch * 11 + 5) & 255);
    endfunction

    function automatic logic src_bit(int n);
        int f, r;
        logic [7:0] v;
        f = n / T1B;
        r = n % T1B;
        if (r == 0) return f[0];
        v = pat(f, (r - 1) / 8);
        return v[7 - ((r - 1) % 8)];
    endfunction

    task automatic chk(logic ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at pos %0d frame %0d: actual %0d expected %0d", req, bpos, bfrm, act, exp);
        end
    endtask

    function automatic int ceil_frame(int n);
        return ((n + T1B - 1) / T1B) * T1B;
    endfunction

    task automatic run(int frames, logic poke, int poke_at);
        int done = 0;
        int last;
        logic [7:0] v;
        int ts, ch, p;
        logic e_ser, e_blank, e_rd, e_sync;
        while (done < frames) begin
            @(negedge clk);
            last = mode_bp ? 255 : T1B - 1;
            if (bpos == 0) begin
                fb = popcnt / T1B;
                pops_in_frame = 0;
            end
            if (!mode_bp) begin
                e_blank = 1'b0;
                e_rd = 1'b1;
                if (bpos == 0) e_ser = fb[0];
                else begin
                    v = pat(fb, (bpos - 1) / 8);
                    e_ser = v[7 - ((bpos - 1) % 8)];
                end
            end else begin
                ts = bpos / 8;
                p = bpos % 8;
                if (ts % 4 == 0) begin
                    e_blank = 1'b1;
                    e_ser = 1'b1;
                    e_rd = (bpos == 0);
                end else begin
                    ch = ts - ts / 4 - 1;
                    v = pat(fb, ch);
                    e_blank = 1'b0;
                    e_ser = v[7 - p];
                    e_rd = 1'b1;
                end
            end
            e_sync = !sync_ext && bpos == 0 && (!sync_mf || bfrm == 0);
            chk(blank_out == e_blank, mode_bp ? "R3 blank" : "R2 blank", int'(blank_out), int'(e_blank));
            chk(ser_out == e_ser, mode_bp ? "R5 data/R3 filler" : "R2 data", int'(ser_out), int'(e_ser));
            chk(rd_en == e_rd, mode_bp ? "R4 read strobe" : "R2 read strobe", int'(rd_en), int'(e_rd));
            chk(sync_out == e_sync, sync_ext ? "R8 sync quiet" : (sync_mf ? "R7 mf sync" : "R6 frame sync"),
                int'(sync_out), int'(e_sync));
            if (rd_en) begin
                popcnt++;
                pops_in_frame++;
            end
            sync_in = poke && (bpos == poke_at) && (done == 0);
            if (sync_in && sync_ext) begin
                bpos = 0;
                bfrm = 0;
                done++;
                popcnt = ceil_frame(popcnt);
            end else if (bpos == last) begin
                chk(pops_in_frame == T1B, "R4 reads per frame", pops_in_frame, T1B);
                bpos = 0;
                bfrm = (bfrm + 1) % MF;
                done++;
            end else begin
                bpos++;
            end
            in_bit = src_bit(popcnt);
        end
    endtask

    task automatic switch_to(logic m, logic ext, logic mf);
        mode_bp = m;
        sync_mf = mf;
        sync_ext = 1'b1;
        sync_in = 1'b1;
        @(posedge clk);
        #1;
        sync_in = 1'b0;
        sync_ext = ext;
        popcnt = ceil_frame(popcnt + 1);
        bpos = 0;
        bfrm = 0;
        in_bit = src_bit(popcnt);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        in_bit = src_bit(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state held
        chk(sync_out == 1'b1, "R1 reset sync_out", int'(sync_out), 1);
        chk(rd_en == 1'b1, "R1 reset rd_en", int'(rd_en), 1);
        chk(blank_out == 1'b0, "R1 reset blank_out", int'(blank_out), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        // R1, R2, R6: pass-through with per-frame sync, starting at frame bit 0
        run(3, 1'b0, 0);
        // R3, R4, R5, R6, R9: mapped mode, sync_in poked but ignored
        switch_to(1'b1, 1'b0, 1'b0);
        run(3, 1'b1, 77);
        // R7: multiframe sync over more than two multiframes
        switch_to(1'b1, 1'b0, 1'b1);
        run(25, 1'b0, 0);
        // R8: external sync realigns mid-frame, sync_out silent
        switch_to(1'b1, 1'b1, 1'b0);
        run(3, 1'b1, 100);
        // R2, R7: pass-through with multiframe pulses
        switch_to(1'b0, 1'b0, 1'b1);
        run(13, 1'b0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule